// File: doc/BRIEF.md
# Input Clock Loss Detector with Limp-Clock Failover

This block watches the oscillator clock that feeds the PLL. It measures it against a backup limp clock that never stops and runs at a low rate (between 1 and 4 MHz). Detection is off until the PLL reports lock. After that, a stretch of limp-clock cycles with no activity on the oscillator counts as a clock failure. On a failure the block moves the system clock over to the limp clock, raises a short reset request that stays inside the device, and sets a failure flag. The external reset pin is never driven by this reset.

Each oscillator edge flips an activity toggle. That toggle crosses into the limp-clock domain through a synchronizer, and a silence counter there looks for changes in it. A state machine in the limp domain has four states:

- `ST_WAIT_LOCK`: not yet armed.
- `ST_ARMED`: watching the oscillator.
- `ST_RST_PULSE`: the internal reset is being driven.
- `ST_LIMP`: terminal state until power-on reset.

It has three transitions:

- `T_LOCKED`: `ST_WAIT_LOCK` to `ST_ARMED`, when the synchronized lock flag is high.
- `T_FAULT`: `ST_ARMED` to `ST_RST_PULSE`, when the silence counter reaches its window.
- `T_PULSE_DONE`: `ST_RST_PULSE` to `ST_LIMP`, after the pulse length has elapsed.

The clock switchover uses a glitch-free mux. Its two enables are cross-coupled, and each enable is retimed on the falling edge of its own clock.

Top module: `clk_loss_monitor`

## Requirements
- R1: After power-on reset, `use_limp`, `int_rst` and `fail_sticky` are 0. Within a few oscillator cycles, `sys_clk` equals `osc_clk`.
- R2: Before `pll_locked` has been seen high, the oscillator may stay silent for any length of time without raising a fault.
- R3: Once armed, a fault is declared after WINDOW consecutive limp-clock cycles with no change in the synchronized activity toggle. The limit is fixed by the synchronizer tolerance: a gap of WINDOW-3 limp cycles or less gives no fault, and a gap of WINDOW+3 or more gives a fault.
- R4: `use_limp` and `fail_sticky` rise on the same limp-clock edge as `int_rst`.
- R5: `int_rst` is high for exactly RST_LEN limp-clock cycles, and it rises only once per fault.
- R6: After a fault, `use_limp` and `fail_sticky` stay 1 until power-on reset, even after the oscillator resumes. No second reset pulse follows.
- R7: Arming is latched. If `pll_locked` drops after the block has armed, a later oscillator loss is still detected.
- R8: Before a fault, `sys_clk` follows `osc_clk`. After the switchover, it follows `limp_clk`. The two mux enables are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Monitored oscillator / external input clock |
| limp_clk | input | 1 | Always-running backup clock, reference for detection |
| pll_locked | input | 1 | PLL lock indication (asynchronous) |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_clk | output | 1 | Glitch-free muxed system clock |
| use_limp | output | 1 | Clock source select, 1 = limp clock |
| int_rst | output | 1 | Internal-only device reset request, active high |
| fail_sticky | output | 1 | Sticky input-clock failure status |

## Verification
The bench builds the block with WINDOW=8, RST_LEN=4 and SYNC_STAGES=2, so every gap length from one limp cycle up to twice the window can be swept, each from a fresh power-on reset. With the window this short, both sides of the detection threshold are within reach. The reset pulse width and the pulse count can be checked on every faulting point of the sweep. Lock-order cases, latched arming, recovery after a fault and the clock selected before and after switchover are run on the same small configuration. The oscillator period is not a harmonic of the limp clock, so the toggle sampling does not alias.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_LOCK = 2'd0,
        ST_ARMED     = 2'd1,
        ST_RST_PULSE = 2'd2,
        ST_LIMP      = 2'd3
    } mon_state_e;

endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (FALLING) begin : g_neg
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_pos
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmon_activity.sv
module clkmon_activity #(
    parameter int WINDOW      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic limp_clk,
    input  logic por_n,
    input  logic arm,
    output logic starved
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    logic          osc_tog;
    logic          tog_s;
    logic          tog_prev;
    logic          change;
    logic [CW-1:0] quiet_cnt;

    // Activity toggle in the oscillator domain
    always_ff @(posedge osc_clk or negedge por_n) begin
        if (!por_n) osc_tog <= 1'b0;
        else        osc_tog <= ~osc_tog;
    end

    clkmon_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_tog_sync (
        .clk   (limp_clk),
        .rst_n (por_n),
        .d     (osc_tog),
        .q     (tog_s)
    );

    always_ff @(posedge limp_clk or negedge por_n) begin
        if (!por_n) tog_prev <= 1'b0;
        else        tog_prev <= tog_s;
    end

    assign change = tog_s ^ tog_prev;

    // Consecutive quiet cycles, counted only while armed
    always_ff @(posedge limp_clk or negedge por_n) begin
        if (!por_n)                quiet_cnt <= '0;
        else if (!arm || change)   quiet_cnt <= '0;
        else if (quiet_cnt != LAST) quiet_cnt <= quiet_cnt + 1'b1;
    end

    assign starved = arm && !change && (quiet_cnt == LAST);
endmodule

// File: rtl/clkmon_fsm.sv
module clkmon_fsm
    import clkmon_pkg::*;
#(
    parameter int RST_LEN = 8
) (
    input  logic       limp_clk,
    input  logic       por_n,
    input  logic       lock_s,
    input  logic       starved,
    output logic       arm,
    output logic       use_limp,
    output logic       int_rst,
    output logic       fail_sticky
);
    localparam int PW = $clog2(RST_LEN + 1);
    localparam logic [PW-1:0] PLAST = PW'(RST_LEN - 1);

    mon_state_e    state_q;
    mon_state_e    state_d;
    logic [PW-1:0] pulse_cnt;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_LOCK: if (lock_s)              state_d = ST_ARMED;     // T_LOCKED
            ST_ARMED:     if (starved)             state_d = ST_RST_PULSE; // T_FAULT
            ST_RST_PULSE: if (pulse_cnt == PLAST)  state_d = ST_LIMP;      // T_PULSE_DONE
            ST_LIMP:                               state_d = ST_LIMP;
            default:                               state_d = ST_WAIT_LOCK;
        endcase
    end

    // State register and pulse timer
    always_ff @(posedge limp_clk or negedge por_n) begin
        if (!por_n) begin
            state_q   <= ST_WAIT_LOCK;
            pulse_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RST_PULSE) pulse_cnt <= pulse_cnt + 1'b1;
            else                         pulse_cnt <= '0;
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge limp_clk or negedge por_n) begin
        if (!por_n) begin
            use_limp    <= 1'b0;
            int_rst     <= 1'b0;
            fail_sticky <= 1'b0;
        end else begin
            unique case (state_d)
                ST_WAIT_LOCK, ST_ARMED: begin
                    use_limp    <= 1'b0;
                    int_rst     <= 1'b0;
                    fail_sticky <= 1'b0;
                end
                ST_RST_PULSE: begin
                    use_limp    <= 1'b1;
                    int_rst     <= 1'b1;
                    fail_sticky <= 1'b1;
                end
                ST_LIMP: begin
                    use_limp    <= 1'b1;
                    int_rst     <= 1'b0;
                    fail_sticky <= 1'b1;
                end
                default: begin
                    use_limp    <= 1'b0;
                    int_rst     <= 1'b0;
                    fail_sticky <= 1'b0;
                end
            endcase
        end
    end

    assign arm = (state_q == ST_ARMED);
endmodule

// File: rtl/clkmon_gfmux.sv
module clkmon_gfmux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic limp_clk,
    input  logic por_n,
    input  logic sel_limp,
    output logic en_osc,
    output logic en_limp,
    output logic clk_out
);
    logic osc_req;
    logic limp_req;
    logic osc_rst_n;

    assign osc_req   = ~sel_limp & ~en_limp;
    assign limp_req  =  sel_limp & ~en_osc;
    // A dead oscillator cannot retire its own enable, so the select clears it
    assign osc_rst_n = por_n & ~sel_limp;

    clkmon_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_osc_en (
        .clk   (osc_clk),
        .rst_n (osc_rst_n),
        .d     (osc_req),
        .q     (en_osc)
    );

    clkmon_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_limp_en (
        .clk   (limp_clk),
        .rst_n (por_n),
        .d     (limp_req),
        .q     (en_limp)
    );

    assign clk_out = (osc_clk & en_osc) | (limp_clk & en_limp);
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
    parameter int WINDOW      = 16,
    parameter int RST_LEN     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic limp_clk,
    input  logic pll_locked,
    input  logic por_n,
    output logic sys_clk,
    output logic use_limp,
    output logic int_rst,
    output logic fail_sticky
);
    logic lock_s;
    logic arm;
    logic starved;
    logic en_osc;
    logic en_limp;

    clkmon_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_lock_sync (
        .clk   (limp_clk),
        .rst_n (por_n),
        .d     (pll_locked),
        .q     (lock_s)
    );

    clkmon_activity #(.WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) u_act (
        .osc_clk  (osc_clk),
        .limp_clk (limp_clk),
        .por_n    (por_n),
        .arm      (arm),
        .starved  (starved)
    );

    clkmon_fsm #(.RST_LEN(RST_LEN)) u_fsm (
        .limp_clk    (limp_clk),
        .por_n       (por_n),
        .lock_s      (lock_s),
        .starved     (starved),
        .arm         (arm),
        .use_limp    (use_limp),
        .int_rst     (int_rst),
        .fail_sticky (fail_sticky)
    );

    clkmon_gfmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
        .osc_clk  (osc_clk),
        .limp_clk (limp_clk),
        .por_n    (por_n),
        .sel_limp (use_limp),
        .en_osc   (en_osc),
        .en_limp  (en_limp),
        .clk_out  (sys_clk)
    );
endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker #(
    parameter int RST_LEN = 8
) (
    input logic limp_clk,
    input logic por_n,
    input logic pll_locked,
    input logic use_limp,
    input logic int_rst,
    input logic fail_sticky,
    input logic en_osc,
    input logic en_limp
);
    logic        seen_lock;
    int unsigned hi_run;
    int unsigned rises;

    always_ff @(posedge limp_clk or negedge por_n) begin
        if (!por_n) begin
            seen_lock <= 1'b0;
            hi_run    <= 0;
            rises     <= 0;
        end else begin
            if (pll_locked) seen_lock <= 1'b1;
            hi_run <= int_rst ? hi_run + 1 : 0;
            if ($rose(int_rst)) rises <= rises + 1;
        end
    end

    AST_NO_FAULT_PRELOCK: assert property (@(posedge limp_clk) disable iff (!por_n)
        $rose(fail_sticky) |-> seen_lock); // R2

    AST_SEL_WITH_RST: assert property (@(posedge limp_clk) disable iff (!por_n)
        int_rst |-> (use_limp && fail_sticky)); // R4

    AST_PULSE_LEN: assert property (@(posedge limp_clk) disable iff (!por_n)
        $fell(int_rst) |-> (hi_run == RST_LEN)); // R5

    AST_ONE_PULSE: assert property (@(posedge limp_clk) disable iff (!por_n)
        $rose(int_rst) |-> (rises == 0)); // R5

    AST_STICKY_FAIL: assert property (@(posedge limp_clk) disable iff (!por_n)
        fail_sticky |=> (fail_sticky && use_limp)); // R6

    AST_ENABLES_EXCL: assert property (@(posedge limp_clk) disable iff (!por_n)
        $onehot0({en_osc, en_limp})); // R8
endmodule

bind clk_loss_monitor clkmon_checker #(.RST_LEN(RST_LEN)) u_chk (
    .limp_clk    (limp_clk),
    .por_n       (por_n),
    .pll_locked  (pll_locked),
    .use_limp    (use_limp),
    .int_rst     (int_rst),
    .fail_sticky (fail_sticky),
    .en_osc      (en_osc),
    .en_limp     (en_limp)
);

// File: tb/sim_clk_loss_monitor.sv
`timescale 1ns/1ps
module sim_clk_loss_monitor;
    localparam int LIMP_PERIOD = 40;
    localparam int OSC_HALF    = 7;
    localparam int WIN         = 8;
    localparam int RLEN        = 4;

    logic osc_clk = 1'b0;
    logic limp_clk = 1'b0;
    logic osc_run = 1'b1;
    logic pll_locked = 1'b0;
    logic por_n = 1'b0;
    logic sys_clk, use_limp, int_rst, fail_sticky;

    int checks = 0;
    int errors = 0;
    int rise_cnt = 0;
    int hi_cnt = 0;
    int r4_bad = 0;
    logic last_rst = 1'b0;

    always #(LIMP_PERIOD/2) limp_clk = ~limp_clk;
    always #(OSC_HALF) if (osc_run) osc_clk = ~osc_clk;

    clk_loss_monitor #(.WINDOW(WIN), .RST_LEN(RLEN), .SYNC_STAGES(2)) u0 (
        .osc_clk     (osc_clk),
        .limp_clk    (limp_clk),
        .pll_locked  (pll_locked),
        .por_n       (por_n),
        .sys_clk     (sys_clk),
        .use_limp    (use_limp),
        .int_rst     (int_rst),
        .fail_sticky (fail_sticky)
    );

    // Pulse monitor sampled away from the active edge
    always @(negedge limp_clk) begin
        if (!por_n) begin
            rise_cnt <= 0; hi_cnt <= 0; r4_bad <= 0; last_rst <= 1'b0;
        end else begin
            if (int_rst && !last_rst) begin
                rise_cnt <= rise_cnt + 1;
                if (!(use_limp && fail_sticky)) r4_bad <= r4_bad + 1;
            end
            if (int_rst) hi_cnt <= hi_cnt + 1;
            last_rst <= int_rst;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic limp_cycles(input int n);
        repeat (n) @(posedge limp_clk);
        #(LIMP_PERIOD/4);
    endtask

    task automatic power_on();
        por_n = 1'b0; pll_locked = 1'b0; osc_run = 1'b1;
        limp_cycles(3);
        por_n = 1'b1;
        limp_cycles(4);
    endtask

    task automatic check_follows_osc(input string tag);
        int bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge osc_clk); #2; if (sys_clk !== osc_clk) bad++;
            @(negedge osc_clk); #2; if (sys_clk !== osc_clk) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        #(LIMP_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state and source selection
        power_on();
        chk(use_limp == 0 && int_rst == 0 && fail_sticky == 0, "R1 reset outputs",
            {use_limp, int_rst, fail_sticky}, 0);
        check_follows_osc("R1 sys_clk follows osc after reset");

        // R2: oscillator silent before lock, then lock arrives
        osc_run = 1'b0;
        limp_cycles(5 * WIN);
        chk(fail_sticky == 0 && rise_cnt == 0, "R2 no fault before lock", fail_sticky, 0);
        pll_locked = 1'b1;
        limp_cycles(WIN + 8);
        chk(fail_sticky == 1, "R2 fault once lock seen with dead osc", fail_sticky, 1);

        // R3/R4/R5: sweep gap lengths, each from power-on
        for (int gap = 1; gap <= 2 * WIN; gap++) begin
            power_on();
            pll_locked = 1'b1;
            limp_cycles(8);
            osc_run = 1'b0;
            limp_cycles(gap);
            osc_run = 1'b1;
            limp_cycles(3 * WIN);
            if (gap <= WIN - 3)
                chk(fail_sticky == 0 && rise_cnt == 0, $sformatf("R3 gap %0d no fault", gap),
                    fail_sticky, 0);
            else if (gap >= WIN + 3) begin
                chk(fail_sticky == 1 && use_limp == 1, $sformatf("R3 gap %0d fault", gap),
                    fail_sticky, 1);
                chk(rise_cnt == 1 && hi_cnt == RLEN, $sformatf("R5 pulse width gap %0d", gap),
                    hi_cnt, RLEN);
                chk(r4_bad == 0, $sformatf("R4 flags with pulse gap %0d", gap), r4_bad, 0);
            end
        end

        // R6: sticky after recovery, no further pulse; R8 limp selected
        limp_cycles(6 * WIN);
        chk(fail_sticky == 1 && use_limp == 1, "R6 sticky after osc returns",
            {fail_sticky, use_limp}, 3);
        chk(rise_cnt == 1, "R6 single pulse", rise_cnt, 1);
        begin
            int bad = 0;
            for (int i = 0; i < 10; i++) begin
                @(posedge limp_clk); #3; if (sys_clk !== 1'b1) bad++;
                @(negedge limp_clk); #3; if (sys_clk !== 1'b0) bad++;
            end
            chk(bad == 0, "R8 sys_clk follows limp after switch", bad, 0);
        end

        // R7: lock drops after arming, loss still caught
        power_on();
        pll_locked = 1'b1;
        limp_cycles(8);
        pll_locked = 1'b0;
        limp_cycles(8);
        chk(fail_sticky == 0, "R7 no fault while osc runs", fail_sticky, 0);
        check_follows_osc("R8 sys_clk follows osc before fault");
        osc_run = 1'b0;
        limp_cycles(WIN + 8);
        chk(fail_sticky == 1 && rise_cnt == 1, "R7 fault after lock dropped", fail_sticky, 1);

        // R6: power-on reset clears the sticky state
        power_on();
        chk(fail_sticky == 0 && use_limp == 0, "R6 cleared by power-on", fail_sticky, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule